// File: doc/BRIEF.md
# Strided DMA Address Generator

This block produces the address sequence for one side (source or destination) of a DMA transfer. A one-cycle start pulse loads a 36-bit base address, built from a 32-bit low word and a 4-bit upper extension. The same pulse loads a per-beat size code, an address movement mode, an optional block/stride pair and a total byte count. The block then offers one beat at a time (address plus byte count) on a valid/ready handshake. It signals completion with a single-cycle done pulse.

Four movement modes are supported: increment, decrement, static (same address on every beat, for FIFO ports) and burst (increment with a burst flag). With stride mode on, the block emits a block of consecutive bytes, then moves the address a further stride bytes in the direction of movement before the next block starts. Beats never cross a block end. The final beat is cut short so that the bytes emitted add up to the byte count exactly.

Top module: `dma_stride_agen`

## Requirements
- R1: After reset, `beat_valid`, `done` and `busy` are all low.
- R2: Size codes 0, 1, 2 and 3 give 1, 2, 4 and 8 bytes per beat, reported on `beat_bytes` as a plain binary count.
- R3: With movement code 0 (increment), each beat address is the previous beat address plus the previous beat's byte count. The first beat starts at the base.
- R4: With movement code 1 (decrement), each beat address is the previous beat address minus the previous beat's byte count. The first beat starts at the base.
- R5: With movement code 2 (static), every beat carries the base address.
- R6: With movement code 3 (burst), addresses advance as in increment mode and `beat_burst` is high on every offered beat. In all other modes `beat_burst` stays low.
- R7: The last beat is shortened when fewer bytes remain than the nominal size, so the sum of `beat_bytes` over all accepted beats equals the byte count.
- R8: When `stride_en` is high and the block size is nonzero, no beat crosses the end of a block. After a block completes, the address moves a further `stride` bytes in the direction of movement (none in static mode), and a new block of the same size starts.
- R9: When `stride_en` is low, or the block size is zero, block size and stride have no effect on the beat sequence.
- R10: The beat address is `{addr_hi, addr_lo}` as a 36-bit value. Arithmetic carries and borrows across bit 32 and wraps modulo 2^36.
- R11: `done` is high for exactly one cycle: the cycle after the final beat is accepted, or the cycle after start when the byte count is zero, in which case no beat is offered.
- R12: While `beat_valid` is high and `beat_ready` is low, `beat_valid`, `beat_addr`, `beat_bytes` and `beat_burst` hold their values into the next cycle.
- R13: A start pulse while `busy` is high is ignored and does not disturb the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load fields and begin a transfer (only when idle) |
| addr_lo | input | 32 | Low 32 bits of the base address |
| addr_hi | input | 4 | Upper address extension |
| size_code | input | 2 | Per-beat size: 0=1, 1=2, 2=4, 3=8 bytes |
| move_code | input | 2 | 0 increment, 1 decrement, 2 static, 3 burst |
| stride_en | input | 1 | Enable block/stride mode |
| blk_size | input | 14 | Bytes per block in stride mode |
| stride | input | 14 | Gap in bytes added after each block |
| byte_count | input | 22 | Total bytes to transfer |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | A beat is offered |
| beat_addr | output | 36 | Beat address |
| beat_bytes | output | 4 | Bytes in this beat (1 to 8) |
| beat_burst | output | 1 | Beat belongs to a burst-mode transfer |
| busy | output | 1 | A transfer is in progress or completing |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default widths: a 32-bit low address, a 4-bit extension, a 22-bit count and 14-bit block and stride fields. At these widths, directed cases can start near 2^32 to exercise the carry into the extension bits. They can also start at address zero in decrement mode to exercise the borrow that wraps to the top of the 36-bit space. Byte counts of up to a few hundred are small enough to cover many blocks and shortened final beats in both stride and plain modes, and the random ready pattern stalls beats at every position in a transfer.

// File: rtl/dsag_pkg.sv
package dsag_pkg;

    localparam int LO_W   = 32;
    localparam int HI_W   = 4;
    localparam int ADDR_W = LO_W + HI_W;
    localparam int CNT_W  = 22;
    localparam int BLK_W  = 14;
    localparam int NB_W   = 4;

    typedef enum logic [1:0] {
        MV_INC    = 2'd0,
        MV_DEC    = 2'd1,
        MV_STATIC = 2'd2,
        MV_BURST  = 2'd3
    } move_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

    typedef struct packed {
        logic [1:0]       size;
        move_e            move;
        logic             strided;
        logic [BLK_W-1:0] blk;
        logic [BLK_W-1:0] stride;
    } cfg_t;

    function automatic logic [NB_W-1:0] nominal_bytes(input logic [1:0] code);
        return NB_W'(1) << code;
    endfunction

    function automatic logic [NB_W-1:0] min_len(input logic [NB_W-1:0] a,
                                                input logic [CNT_W-1:0] b);
        if (CNT_W'(a) > b) return b[NB_W-1:0];
        return a;
    endfunction

endpackage

// File: rtl/dsag_len.sv
module dsag_len
    import dsag_pkg::*;
(
    input  logic [1:0]       size,
    input  logic             strided,
    input  logic [CNT_W-1:0] remain,
    input  logic [BLK_W-1:0] blk_left,
    output logic [NB_W-1:0]  nbytes,
    output logic             blk_end,
    output logic             last
);
    logic [NB_W-1:0] cap_rem;
    logic [NB_W-1:0] cap_blk;

    always_comb begin
        cap_rem = min_len(nominal_bytes(size), remain);
        cap_blk = min_len(cap_rem, CNT_W'(blk_left));
        nbytes  = strided ? cap_blk : cap_rem;
        blk_end = strided && (BLK_W'(nbytes) == blk_left);
        last    = (CNT_W'(nbytes) == remain);
    end
endmodule

// File: rtl/dsag_ctrl.sv
module dsag_ctrl
    import dsag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  cfg_t             cfg_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic             accept,
    input  logic [NB_W-1:0]  nbytes,
    input  logic             last,
    output logic             load,
    output cfg_t             cfg_q,
    output logic [CNT_W-1:0] remain_q,
    output logic             valid,
    output logic             busy,
    output logic             done
);
    state_e state_q;

    assign load  = start && (state_q == ST_IDLE);
    assign valid = (state_q == ST_RUN);
    assign busy  = (state_q != ST_IDLE);
    assign done  = (state_q == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            cfg_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (load) begin
                    cfg_q    <= cfg_in;
                    remain_q <= count_in;
                    state_q  <= (count_in == '0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: if (accept) begin
                    remain_q <= remain_q - CNT_W'(nbytes);
                    if (last) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                   // R11
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (accept && last) |=> (done && !valid));                            // R11
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && valid) |=> $stable(cfg_q));                              // R13
endmodule

// File: rtl/dsag_addr.sv
module dsag_addr
    import dsag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [BLK_W-1:0]  blk_in,
    input  cfg_t              cfg_q,
    input  logic              accept,
    input  logic              valid,
    input  logic [NB_W-1:0]   nbytes,
    input  logic              blk_end,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BLK_W-1:0]  blk_left_q
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] addr_nx;

    always_comb begin
        step = ADDR_W'(nbytes);
        if (blk_end) step = step + ADDR_W'(cfg_q.stride);
        case (cfg_q.move)
            MV_DEC:    addr_nx = addr_q - step;
            MV_STATIC: addr_nx = addr_q;
            default:   addr_nx = addr_q + step;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            blk_left_q <= '0;
        end else if (load) begin
            addr_q     <= base;
            blk_left_q <= blk_in;
        end else if (accept) begin
            addr_q     <= addr_nx;
            blk_left_q <= blk_end ? cfg_q.blk : (blk_left_q - BLK_W'(nbytes));
        end
    end

    AST_STATIC_ADDR: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(valid) && cfg_q.move == MV_STATIC) |-> $stable(addr_q)); // R5
    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(accept) && cfg_q.move == MV_INC && !cfg_q.strided)
        |-> (addr_q == $past(addr_q) + ADDR_W'($past(nbytes))));          // R3
endmodule

// File: rtl/dma_stride_agen.sv
module dma_stride_agen
    import dsag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [LO_W-1:0]       addr_lo,
    input  logic [HI_W-1:0]       addr_hi,
    input  logic [1:0]            size_code,
    input  logic [1:0]            move_code,
    input  logic                  stride_en,
    input  logic [BLK_W-1:0]      blk_size,
    input  logic [BLK_W-1:0]      stride,
    input  logic [CNT_W-1:0]      byte_count,
    input  logic                  beat_ready,
    output logic                  beat_valid,
    output logic [ADDR_W-1:0]     beat_addr,
    output logic [NB_W-1:0]       beat_bytes,
    output logic                  beat_burst,
    output logic                  busy,
    output logic                  done
);
    cfg_t             cfg_in;
    cfg_t             cfg_q;
    logic             load;
    logic [CNT_W-1:0] remain_q;
    logic [BLK_W-1:0] blk_left_q;
    logic [NB_W-1:0]  nbytes;
    logic             blk_end;
    logic             last;
    logic             accept;

    always_comb begin
        cfg_in.size    = size_code;
        cfg_in.move    = move_e'(move_code);
        cfg_in.strided = stride_en && (blk_size != '0);
        cfg_in.blk     = blk_size;
        cfg_in.stride  = stride;
    end

    assign accept = beat_valid && beat_ready;

    dsag_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cfg_in(cfg_in),
        .count_in(byte_count), .accept(accept), .nbytes(nbytes), .last(last),
        .load(load), .cfg_q(cfg_q), .remain_q(remain_q),
        .valid(beat_valid), .busy(busy), .done(done)
    );

    dsag_len u_len (
        .size(cfg_q.size), .strided(cfg_q.strided), .remain(remain_q),
        .blk_left(blk_left_q), .nbytes(nbytes), .blk_end(blk_end), .last(last)
    );

    dsag_addr u_addr (
        .clk(clk), .rst(rst), .load(load), .base({addr_hi, addr_lo}),
        .blk_in(blk_size), .cfg_q(cfg_q), .accept(accept), .valid(beat_valid),
        .nbytes(nbytes), .blk_end(blk_end), .addr_q(beat_addr),
        .blk_left_q(blk_left_q)
    );

    assign beat_bytes = beat_valid ? nbytes : '0;
    assign beat_burst = beat_valid && (cfg_q.move == MV_BURST);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=>
        (beat_valid && $stable(beat_addr) && $stable(beat_bytes) && $stable(beat_burst))); // R12
    AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (beat_bytes != '0 && beat_bytes <= NB_W'(8)));      // R2
    AST_BURST_FLAG: assert property (@(posedge clk) disable iff (rst)
        beat_burst |-> beat_valid);                                        // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!beat_valid && !done));                                 // R1
endmodule

// File: tb/dma_stride_agen_tb_top.sv
module dma_stride_agen_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic [31:0] addr_lo = 0;
    logic [3:0]  addr_hi = 0;
    logic [1:0]  size_code = 0, move_code = 0;
    logic        stride_en = 0;
    logic [13:0] blk_size = 0, stride = 0;
    logic [21:0] byte_count = 0;
    logic        beat_ready = 0;
    logic        beat_valid, beat_burst, busy, done;
    logic [35:0] beat_addr;
    logic [3:0]  beat_bytes;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [35:0] exp_addr [0:511];
    int          exp_n    [0:511];
    int          nbeats;

    always #10 clk = ~clk;

    dma_stride_agen dut_i (
        .clk(clk), .rst(rst), .start(start), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .size_code(size_code), .move_code(move_code), .stride_en(stride_en),
        .blk_size(blk_size), .stride(stride), .byte_count(byte_count),
        .beat_ready(beat_ready), .beat_valid(beat_valid), .beat_addr(beat_addr),
        .beat_bytes(beat_bytes), .beat_burst(beat_burst), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    // Reference beat list built from the requirements
    function automatic void build(input logic [35:0] base, input int sz, input int mv,
                                  input bit sen, input int blk, input int strd,
                                  input int cnt);
        logic [35:0] a = base;
        int rem = cnt;
        bit sact = sen && (blk != 0);
        int bl = blk;
        int n;
        nbeats = 0;
        while (rem > 0) begin
            n = 1 << sz;
            if (n > rem) n = rem;
            if (sact && n > bl) n = bl;
            exp_addr[nbeats] = a;
            exp_n[nbeats] = n;
            nbeats++;
            rem -= n;
            bl -= n;
            if (mv != 2) begin
                if (mv == 1) a = a - 36'(n); else a = a + 36'(n);
                if (sact && bl == 0) begin
                    if (mv == 1) a = a - 36'(strd); else a = a + 36'(strd);
                end
            end
            if (sact && bl == 0) bl = blk;
        end
    endfunction

    task automatic run_tx(input logic [35:0] base, input int sz, input int mv,
                          input bit sen, input int blk, input int strd, input int cnt,
                          input string tag, input bit inject);
        int idx = 0;
        bit injected = 0;
        bit rdy;
        build(base, sz, mv, sen, blk, strd, cnt);
        addr_lo = base[31:0]; addr_hi = base[35:32];
        size_code = 2'(sz); move_code = 2'(mv); stride_en = sen;
        blk_size = 14'(blk); stride = 14'(strd); byte_count = 22'(cnt);
        start = 1;
        @(negedge clk);
        start = 0;
        while (idx < nbeats) begin
            chk(beat_valid === 1'b1, tag, 64'(beat_valid), 1);
            chk(beat_addr === exp_addr[idx], tag, 64'(beat_addr), 64'(exp_addr[idx]));
            chk(beat_bytes === 4'(exp_n[idx]),
                (exp_n[idx] < (1 << sz)) ? "R7" : "R2", 64'(beat_bytes), 64'(exp_n[idx]));
            chk(beat_burst === (mv == 3), "R6", 64'(beat_burst), 64'(mv == 3));
            rdy = ($urandom % 4) != 0;
            if (inject && idx == 1 && !injected) begin
                injected = 1;
                start = 1;  // R13: must be ignored
                addr_lo = 32'h5555_0000; move_code = 2'd2; byte_count = 22'd3;
                size_code = 2'd0; stride_en = 0;
            end else begin
                start = 0;
            end
            beat_ready = rdy;
            @(negedge clk);
            if (rdy) idx++;
        end
        start = 0;
        beat_ready = 0;
        chk(done === 1'b1 && beat_valid === 1'b0, "R11", 64'({done, beat_valid}), 64'b10);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R11", 64'({done, busy}), 64'b00);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(beat_valid === 0 && done === 0 && busy === 0, "R1",
            64'({beat_valid, done, busy}), 0);
        rst = 0;
        @(negedge clk);
        chk(beat_valid === 0 && done === 0 && busy === 0, "R1",
            64'({beat_valid, done, busy}), 0);

        // Directed corner cases
        run_tx(36'h0_0000_1000, 0, 0, 0, 0, 0, 5,  "R3", 0);
        run_tx(36'h0_0000_2000, 1, 0, 0, 0, 0, 8,  "R2", 0);
        run_tx(36'h0_0000_3000, 2, 1, 0, 0, 0, 16, "R4", 0);
        run_tx(36'h0_0000_4000, 3, 2, 0, 0, 0, 24, "R5", 0);
        run_tx(36'h0_0000_5000, 3, 3, 0, 0, 0, 13, "R6", 0);
        run_tx(36'h0_0000_6000, 3, 0, 0, 0, 0, 13, "R7", 0);
        run_tx(36'h0_0000_0100, 1, 0, 1, 3, 10, 7, "R8", 0);
        run_tx(36'h0_0000_0800, 2, 1, 1, 6, 20, 30, "R8", 0);
        run_tx(36'h0_0000_0900, 0, 0, 0, 4, 100, 9, "R9", 0);
        run_tx(36'h0_0000_0A00, 1, 0, 1, 0, 100, 9, "R9", 0);
        run_tx(36'h3_FFFF_FFFC, 2, 0, 0, 0, 0, 12, "R10", 0);
        run_tx(36'h0_0000_0000, 0, 1, 0, 0, 0, 3,  "R10", 0);
        run_tx(36'h0_0000_7000, 0, 0, 0, 0, 0, 0,  "R11", 0);
        run_tx(36'h0_0000_8000, 1, 0, 0, 0, 0, 20, "R13", 1);
        run_tx(36'h0_0000_9000, 0, 3, 1, 5, 2, 17, "R12", 0);

        // Constrained random transfers
        for (int t = 0; t < 60; t++) begin
            logic [35:0] b = {4'($urandom), 32'($urandom)};
            int mv = $urandom % 4;
            string tg;
            bit sen = $urandom % 2;
            int blk = $urandom % 21;
            case (mv)
                0: tg = "R3";
                1: tg = "R4";
                2: tg = "R5";
                default: tg = "R6";
            endcase
            if (sen && blk != 0) tg = "R8";
            run_tx(b, $urandom % 4, mv, sen, blk, $urandom % 51,
                   1 + ($urandom % 120), tg, (t % 7) == 3);
        end
        finish_run();
    end
endmodule